// File: doc/BRIEF.md
# Two-Dimensional Parity Block Checker

The block protects a block of `NUM_WORDS` words, each `WORD_W` bits wide, with odd parity along two axes. Each word gets one parity bit. Each bit position gets one parity bit taken across every word of the block. In generate mode the block takes the words one per accepted cycle. It returns each word's parity bit one cycle later. One cycle after the last word it returns the parity row for the columns.

In check mode the same block is streamed back together with its stored parities. The block counts how many word parities fail and how many column parities fail. It then sorts the result into one of five cases:
- clean;
- a single data-bit error, located where the failing word meets the failing column;
- an error in a stored word-parity bit;
- an error in a stored column-parity bit;
- an uncorrectable pattern.

The data itself is held elsewhere. A correction port takes any word that is read back together with its index. If the reported data error lies in that word, the port returns the word with the faulty bit inverted.

Top module: `tdp_parity_chk`

## Requirements
- R1: One cycle after each accepted word of a generate-mode block, `row_par_vld_o` is 1. `row_par_o` is the bit that makes the total count of ones in that word plus the bit odd. `row_par_o` holds its value between such words.
- R2: One cycle after the last word of a generate-mode block, `done_o` pulses. Each bit j of `col_par_o` makes the count of ones in bit j across all words plus that bit odd. `status_o` becomes 0 and both locations become 0. `col_par_o` changes only at the end of a generate-mode block.
- R3: A block is `NUM_WORDS` consecutive accepted words. Idle cycles between words do not end a block. All accumulators restart at the first word, so no block depends on the one before it, even when blocks are sent back to back.
- R4: The mode is taken from `mode_i` on the first word of a block (0 generate, 1 check). Values of `mode_i` on later words of the block have no effect.
- R5: In check mode the result appears one cycle after the last word, together with a single-cycle `done_o`. The stored column parities are taken from `col_par_i` on that last word. A block whose parities all hold gives `status_o` = 0.
- R6: Exactly one failing word parity together with exactly one failing column parity gives `status_o` = 1. `err_row_o` is the failing word's 0-based position in arrival order, and `err_col_o` is the failing bit position.
- R7: Exactly one failing word parity with no failing column gives `status_o` = 2, with `err_row_o` set to that word and `err_col_o` = 0.
- R8: Exactly one failing column with no failing word parity gives `status_o` = 3, with `err_col_o` set to that bit and `err_row_o` = 0.
- R9: Any other pattern, with two or more failing word parities or two or more failing columns, gives `status_o` = 4 with both locations at 0.
- R10: While `status_o` = 1 and `fix_idx_i` equals `err_row_o`, `fix_word_o` equals `fix_word_i` with bit `err_col_o` inverted. In every other case `fix_word_o` equals `fix_word_i`.
- R11: After reset, `done_o`, `row_par_vld_o`, `row_par_o`, `col_par_o`, `status_o`, `err_row_o` and `err_col_o` are all 0.
- R12: `status_o`, `err_row_o` and `err_col_o` keep their values until the next block completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A word is present this cycle |
| mode_i | input | 1 | 0 generate, 1 check; taken on the first word |
| word_i | input | WORD_W | Data word |
| row_par_i | input | 1 | Stored parity of this word (check mode) |
| col_par_i | input | WORD_W | Stored column parities, taken on the last word (check mode) |
| row_par_o | output | 1 | Generated parity of the previous word |
| row_par_vld_o | output | 1 | `row_par_o` is fresh this cycle |
| col_par_o | output | WORD_W | Generated column parities of the last generate block |
| done_o | output | 1 | Block complete; result updated this cycle |
| status_o | output | 3 | 0 clean, 1 data bit, 2 word parity bit, 3 column parity bit, 4 uncorrectable |
| err_row_o | output | $clog2(NUM_WORDS) | Word index of the located error |
| err_col_o | output | $clog2(WORD_W) | Bit index of the located error |
| fix_idx_i | input | $clog2(NUM_WORDS) | Index of the word offered for correction |
| fix_word_i | input | WORD_W | Word offered for correction |
| fix_word_o | output | WORD_W | Offered word, corrected when the result says so |

## Verification
The properties assume the following about the inputs:
- reset is applied before the first word;
- `NUM_WORDS` is at least 2, so `done_o` never lasts more than one cycle;
- the correction inputs are only read as a pair with the latched result.

The stimulus keeps to these assumptions. Its inputs change only between clock edges. It offers words both in unbroken runs and with idle gaps. It sends the stored column parities on the last word of every check block, and it holds the correction inputs steady while it samples them.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_DATA    = 3'd1,
    ST_ROW_PAR = 3'd2,
    ST_COL_PAR = 3'd3,
    ST_MULTI   = 3'd4
  } tdp_status_e;

  // saturating 0,1,2+ failure counter
  function automatic logic [1:0] sat_inc(input logic [1:0] v);
    return (v == 2'd2) ? 2'd2 : v + 2'd1;
  endfunction

endpackage

// File: rtl/tdp_row_track.sv
module tdp_row_track #(
  parameter int WORD_W = 16,
  parameter int ROW_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              first_i,
  input  logic [ROW_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              par_i,
  output logic              gen_par_o,
  output logic [1:0]        fail_cnt_o,
  output logic [ROW_W-1:0]  fail_idx_o
);
  import tdp_pkg::*;

  logic [1:0]       cnt_q, base_cnt;
  logic [ROW_W-1:0] idx_q, base_idx;
  logic             fail;

  always_comb begin
    gen_par_o = ~(^word_i);
    fail      = vld_i & ~((^word_i) ^ par_i);
    base_cnt  = first_i ? 2'd0 : cnt_q;
    base_idx  = first_i ? '0 : idx_q;
    fail_cnt_o = fail ? sat_inc(base_cnt) : base_cnt;
    fail_idx_o = (fail && base_cnt == 2'd0) ? idx_i : base_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= 2'd0;
      idx_q <= '0;
    end else if (vld_i) begin
      cnt_q <= fail_cnt_o;
      idx_q <= fail_idx_o;
    end
  end

endmodule

// File: rtl/tdp_col_track.sv
module tdp_col_track #(
  parameter int WORD_W = 16,
  parameter int COL_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              first_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] par_i,
  output logic [WORD_W-1:0] gen_par_o,
  output logic [1:0]        fail_cnt_o,
  output logic [COL_W-1:0]  fail_idx_o
);
  import tdp_pkg::*;

  logic [WORD_W-1:0] acc_q, acc_nxt, fail_vec;

  for (genvar j = 0; j < WORD_W; j++) begin : g_col
    assign acc_nxt[j]   = (first_i ? 1'b0 : acc_q[j]) ^ word_i[j];
    assign gen_par_o[j] = ~acc_nxt[j];
    assign fail_vec[j]  = ~(acc_nxt[j] ^ par_i[j]);
  end

  // lowest failing column and saturated count
  always_comb begin
    fail_cnt_o = 2'd0;
    fail_idx_o = '0;
    for (int j = WORD_W - 1; j >= 0; j--) begin
      if (fail_vec[j]) begin
        fail_idx_o = COL_W'(j);
        fail_cnt_o = sat_inc(fail_cnt_o);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (vld_i) acc_q <= acc_nxt;
  end

endmodule

// File: rtl/tdp_fix.sv
module tdp_fix #(
  parameter int WORD_W = 16,
  parameter int ROW_W  = 3,
  parameter int COL_W  = 4
) (
  input  tdp_pkg::tdp_status_e status_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [COL_W-1:0]     col_i,
  input  logic [ROW_W-1:0]     idx_i,
  input  logic [WORD_W-1:0]    word_i,
  output logic [WORD_W-1:0]    word_o
);
  import tdp_pkg::*;

  logic [WORD_W-1:0] mask;

  always_comb begin
    mask = '0;
    if (status_i == ST_DATA && idx_i == row_i) mask = WORD_W'(1) << col_i;
    word_o = word_i ^ mask;
  end

endmodule

// File: rtl/tdp_parity_chk.sv
module tdp_parity_chk #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 16,
  localparam int ROW_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int COL_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              row_par_i,
  input  logic [WORD_W-1:0] col_par_i,
  output logic              row_par_o,
  output logic              row_par_vld_o,
  output logic [WORD_W-1:0] col_par_o,
  output logic              done_o,
  output logic [2:0]        status_o,
  output logic [ROW_W-1:0]  err_row_o,
  output logic [COL_W-1:0]  err_col_o,
  input  logic [ROW_W-1:0]  fix_idx_i,
  input  logic [WORD_W-1:0] fix_word_i,
  output logic [WORD_W-1:0] fix_word_o
);
  import tdp_pkg::*;

  localparam logic [ROW_W-1:0] LAST_IDX = ROW_W'(NUM_WORDS - 1);

  logic [ROW_W-1:0]  cnt_q;
  logic              mode_q, chk_mode, first, last;
  logic              row_gen;
  logic [1:0]        row_fail_cnt, col_fail_cnt;
  logic [ROW_W-1:0]  row_fail_idx;
  logic [COL_W-1:0]  col_fail_idx;
  logic [WORD_W-1:0] col_gen;

  tdp_status_e       cls_st, status_q;
  logic [ROW_W-1:0]  cls_row, row_q;
  logic [COL_W-1:0]  cls_col, col_q;
  logic [WORD_W-1:0] col_par_q;
  logic              done_q, rpv_q, rp_q;

  assign first    = valid_i && (cnt_q == '0);
  assign last     = valid_i && (cnt_q == LAST_IDX);
  assign chk_mode = first ? mode_i : mode_q;

  tdp_row_track #(.WORD_W(WORD_W), .ROW_W(ROW_W)) u_row (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (valid_i),
    .first_i    (first),
    .idx_i      (cnt_q),
    .word_i     (word_i),
    .par_i      (row_par_i),
    .gen_par_o  (row_gen),
    .fail_cnt_o (row_fail_cnt),
    .fail_idx_o (row_fail_idx)
  );

  tdp_col_track #(.WORD_W(WORD_W), .COL_W(COL_W)) u_col (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (valid_i),
    .first_i    (first),
    .word_i     (word_i),
    .par_i      (col_par_i),
    .gen_par_o  (col_gen),
    .fail_cnt_o (col_fail_cnt),
    .fail_idx_o (col_fail_idx)
  );

  // classify the failure pattern
  always_comb begin
    cls_st  = ST_MULTI;
    cls_row = '0;
    cls_col = '0;
    if (row_fail_cnt == 2'd0 && col_fail_cnt == 2'd0) begin
      cls_st = ST_OK;
    end else if (row_fail_cnt == 2'd1 && col_fail_cnt == 2'd1) begin
      cls_st  = ST_DATA;
      cls_row = row_fail_idx;
      cls_col = col_fail_idx;
    end else if (row_fail_cnt == 2'd1 && col_fail_cnt == 2'd0) begin
      cls_st  = ST_ROW_PAR;
      cls_row = row_fail_idx;
    end else if (row_fail_cnt == 2'd0 && col_fail_cnt == 2'd1) begin
      cls_st  = ST_COL_PAR;
      cls_col = col_fail_idx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      done_q    <= 1'b0;
      rpv_q     <= 1'b0;
      rp_q      <= 1'b0;
      col_par_q <= '0;
      status_q  <= ST_OK;
      row_q     <= '0;
      col_q     <= '0;
    end else begin
      done_q <= last;
      rpv_q  <= valid_i && !chk_mode;
      if (valid_i && !chk_mode) rp_q <= row_gen;
      if (first) mode_q <= mode_i;
      if (valid_i) cnt_q <= last ? '0 : cnt_q + ROW_W'(1);
      if (last) begin
        if (chk_mode) begin
          status_q <= cls_st;
          row_q    <= cls_row;
          col_q    <= cls_col;
        end else begin
          status_q  <= ST_OK;
          row_q     <= '0;
          col_q     <= '0;
          col_par_q <= col_gen;
        end
      end
    end
  end

  tdp_fix #(.WORD_W(WORD_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_fix (
    .status_i (status_q),
    .row_i    (row_q),
    .col_i    (col_q),
    .idx_i    (fix_idx_i),
    .word_i   (fix_word_i),
    .word_o   (fix_word_o)
  );

  assign row_par_o     = rp_q;
  assign row_par_vld_o = rpv_q;
  assign col_par_o     = col_par_q;
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign err_row_o     = row_q;
  assign err_col_o     = col_q;

endmodule

// File: rtl/tdp_parity_chk_sva.sv
module tdp_parity_chk_sva #(
  parameter int NUM_WORDS = 8,
  parameter int WORD_W    = 16,
  localparam int ROW_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int COL_W    = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              mode_i,
  input logic [WORD_W-1:0] word_i,
  input logic              row_par_i,
  input logic [WORD_W-1:0] col_par_i,
  input logic              row_par_o,
  input logic              row_par_vld_o,
  input logic [WORD_W-1:0] col_par_o,
  input logic              done_o,
  input logic [2:0]        status_o,
  input logic [ROW_W-1:0]  err_row_o,
  input logic [COL_W-1:0]  err_col_o,
  input logic [ROW_W-1:0]  fix_idx_i,
  input logic [WORD_W-1:0] fix_word_i,
  input logic [WORD_W-1:0] fix_word_o
);

  a_r1_vld_follows_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_par_vld_o |-> $past(valid_i));

  a_r5_done_follows_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i));

  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_colpar_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(col_par_o));

  a_r6_loc_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd1) |-> (int'(err_row_o) < NUM_WORDS && int'(err_col_o) < WORD_W));

  a_r7_rowpar_col_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd2) |-> (err_col_o == '0));

  a_r8_colpar_row_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd3) |-> (err_row_o == '0));

  a_r10_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 3'd1) |-> (fix_word_o == fix_word_i));

  a_r10_one_bit_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 3'd1 && fix_idx_i == err_row_o) |-> ($countones(fix_word_o ^ fix_word_i) == 1));

  a_r12_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(status_o) && $stable(err_row_o) && $stable(err_col_o)));

endmodule

bind tdp_parity_chk tdp_parity_chk_sva #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_sva (.*);

// File: tb/tdp_parity_chk_tb.sv
module tdp_parity_chk_tb_top;
  localparam int K     = 8;
  localparam int N     = 16;
  localparam int ROW_W = $clog2(K);
  localparam int COL_W = $clog2(N);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0, mode_i = 1'b0, row_par_i = 1'b0;
  logic [N-1:0] word_i = '0, col_par_i = '0, fix_word_i = '0;
  logic [ROW_W-1:0] fix_idx_i = '0;
  logic row_par_o, row_par_vld_o, done_o;
  logic [N-1:0] col_par_o, fix_word_o;
  logic [2:0] status_o;
  logic [ROW_W-1:0] err_row_o;
  logic [COL_W-1:0] err_col_o;

  always #10 clk_i = ~clk_i;

  tdp_parity_chk #(.NUM_WORDS(K), .WORD_W(N)) dut_i (.*);

  int checks = 0, errors = 0;
  string scen = "init";

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%0h expected=%0h", tag, what, scen, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int m_cnt = 0;
  bit m_mode = 0;
  logic [N-1:0] q_w[$];
  bit q_rp[$];
  bit exp_done = 0, exp_rpv = 0, exp_rp = 0;
  logic [N-1:0] exp_cp = '0;
  int exp_st = 0, exp_row = 0, exp_col = 0;
  string exp_tag = "R5";

  task automatic evaluate();
    int nrf, fr, ncf, fc, ones;
    if (!m_mode) begin
      for (int j = 0; j < N; j++) begin
        ones = 0;
        for (int i = 0; i < K; i++) ones += q_w[i][j];
        exp_cp[j] = (ones % 2 == 0);
      end
      exp_st = 0; exp_row = 0; exp_col = 0; exp_tag = "R2";
      return;
    end
    nrf = 0; fr = -1; ncf = 0; fc = -1;
    for (int i = 0; i < K; i++) begin
      ones = $countones(q_w[i]) + q_rp[i];
      if (ones % 2 == 0) begin nrf++; if (fr < 0) fr = i; end
    end
    for (int j = 0; j < N; j++) begin
      ones = col_par_i[j];
      for (int i = 0; i < K; i++) ones += q_w[i][j];
      if (ones % 2 == 0) begin ncf++; if (fc < 0) fc = j; end
    end
    exp_row = 0; exp_col = 0;
    if (nrf == 0 && ncf == 0) begin exp_st = 0; exp_tag = "R5"; end
    else if (nrf == 1 && ncf == 1) begin exp_st = 1; exp_row = fr; exp_col = fc; exp_tag = "R6"; end
    else if (nrf == 1 && ncf == 0) begin exp_st = 2; exp_row = fr; exp_tag = "R7"; end
    else if (nrf == 0 && ncf == 1) begin exp_st = 3; exp_col = fc; exp_tag = "R8"; end
    else begin exp_st = 4; exp_tag = "R9"; end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; exp_done = 0; exp_rpv = 0; exp_rp = 0; exp_cp = '0;
      exp_st = 0; exp_row = 0; exp_col = 0;
    end else begin
      exp_done = 0;
      exp_rpv  = 0;
      if (valid_i) begin
        if (m_cnt == 0) begin
          m_mode = mode_i;
          q_w.delete();
          q_rp.delete();
        end
        q_w.push_back(word_i);
        q_rp.push_back(row_par_i);
        if (!m_mode) begin
          exp_rpv = 1;
          exp_rp  = ($countones(word_i) % 2 == 0);
        end
        if (m_cnt == K - 1) begin
          evaluate();
          exp_done = 1;
          m_cnt = 0;
        end else m_cnt++;
      end
    end
  end

  // compare on every clock, away from the active edge
  bit wd_hit = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !wd_hit) begin
      check(done_o == exp_done, exp_tag, "done", done_o, exp_done);
      check(row_par_vld_o == exp_rpv, "R1", "row_par_vld", row_par_vld_o, exp_rpv);
      check(row_par_o == exp_rp, "R1", "row_par", row_par_o, exp_rp);
      check(col_par_o == exp_cp, "R2", "col_par", col_par_o, exp_cp);
      check(int'(status_o) == exp_st, exp_done ? exp_tag : "R12", "status", status_o, exp_st);
      check(int'(err_row_o) == exp_row, exp_done ? exp_tag : "R12", "err_row", err_row_o, exp_row);
      check(int'(err_col_o) == exp_col, exp_done ? exp_tag : "R12", "err_col", err_col_o, exp_col);
    end
  end

  // ---------------- stimulus ----------------
  logic [N-1:0] blk_w[K];
  bit blk_rp[K];
  logic [N-1:0] blk_cp;

  task automatic build_clean();
    logic [N-1:0] x;
    x = '0;
    for (int i = 0; i < K; i++) begin
      blk_w[i]  = N'($urandom);
      blk_rp[i] = ~(^blk_w[i]);
      x ^= blk_w[i];
    end
    blk_cp = ~x;
  endtask

  task automatic send(input bit mode, input bit gap, input bit toggle);
    for (int i = 0; i < K; i++) begin
      @(negedge clk_i); #1;
      valid_i   = 1'b1;
      mode_i    = (i == 0) ? mode : (toggle ? ~mode : mode);
      word_i    = blk_w[i];
      row_par_i = blk_rp[i];
      col_par_i = blk_cp;
      if (gap) begin
        @(negedge clk_i); #1;
        valid_i = 1'b0;
        word_i  = N'($urandom);
        mode_i  = ~mode_i;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); #1;
      valid_i = 1'b0;
    end
  endtask

  // R10: offer a word for correction; flip_col < 0 means no change expected
  task automatic probe(input int idx, input int flip_col);
    logic [N-1:0] w, e;
    @(negedge clk_i); #1;
    w = N'($urandom);
    fix_idx_i  = ROW_W'(idx);
    fix_word_i = w;
    #2;
    e = (flip_col >= 0) ? (w ^ (N'(1) << flip_col)) : w;
    check(fix_word_o == e, "R10", "fix_word", fix_word_o, e);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset values
    check(done_o == 0 && row_par_vld_o == 0 && row_par_o == 0, "R11", "ctl", {done_o, row_par_vld_o, row_par_o}, 0);
    check(col_par_o == '0, "R11", "col_par", col_par_o, 0);
    check(status_o == 0 && err_row_o == 0 && err_col_o == 0, "R11", "result", {status_o, err_row_o, err_col_o}, 0);
    #1 rst_ni = 1'b1;
    idle(2);

    scen = "R1 R2 generate";
    build_clean(); send(0, 0, 0); idle(3);
    scen = "R3 generate with gaps";
    build_clean(); send(0, 1, 0); idle(3);
    scen = "R5 clean check";
    build_clean(); send(1, 0, 0); idle(3);

    scen = "R6 data flip 3,5";
    build_clean(); blk_w[3][5] = ~blk_w[3][5]; send(1, 0, 0); idle(3);
    probe(3, 5); probe(2, -1);
    scen = "R6 data flip 0,0";
    build_clean(); blk_w[0][0] = ~blk_w[0][0]; send(1, 1, 0); idle(3);
    probe(0, 0);
    scen = "R6 data flip last,last";
    build_clean(); blk_w[K-1][N-1] = ~blk_w[K-1][N-1]; send(1, 0, 0); idle(3);
    probe(K - 1, N - 1); probe(0, -1);

    scen = "R7 row parity flip";
    build_clean(); blk_rp[6] = ~blk_rp[6]; send(1, 0, 0); idle(3);
    probe(6, -1);
    scen = "R8 column parity flip";
    build_clean(); blk_cp[9] = ~blk_cp[9]; send(1, 0, 0); idle(3);
    probe(0, -1);

    scen = "R9 two flips same word";
    build_clean(); blk_w[2][1] = ~blk_w[2][1]; blk_w[2][7] = ~blk_w[2][7]; send(1, 0, 0); idle(3);
    probe(2, -1);
    scen = "R9 two flips apart";
    build_clean(); blk_w[1][3] = ~blk_w[1][3]; blk_w[5][10] = ~blk_w[5][10]; send(1, 0, 0); idle(3);
    scen = "R9 two row parity flips";
    build_clean(); blk_rp[1] = ~blk_rp[1]; blk_rp[4] = ~blk_rp[4]; send(1, 0, 0); idle(3);

    scen = "R4 mode toggled in check block";
    build_clean(); blk_w[4][2] = ~blk_w[4][2]; send(1, 0, 1); idle(3);
    scen = "R4 mode toggled in generate block";
    build_clean(); send(0, 1, 1); idle(3);

    scen = "R3 back to back";
    build_clean(); blk_w[6][12] = ~blk_w[6][12]; send(1, 0, 0);
    build_clean(); send(1, 0, 0);
    build_clean(); send(0, 0, 0); idle(3);

    scen = "done";
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    wd_hit = 1;
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=complete");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule